// File: doc/BRIEF.md
# SPI Master with Register Access and FIFOs

This block is a serial peripheral interface master sitting behind a plain 32-bit register bus. Software writes words into a transmit FIFO through a data register and reads received words out of a receive FIFO through the same address. A shift engine moves each word onto the serial line in clock mode 0: the clock idles low, output data changes on the falling edge and input data is captured on the rising edge. The serial clock comes from a programmable divider.

Frame length, bit order and an internal loopback path are set in the control registers. Transmission, driving of the data output and capture of received data each have their own enable. One of four chip-select lines is chosen by a register field, and its level is set directly by software rather than pulsed per frame. A status register reports the FIFO fill levels, a transmit-not-full flag, a receive-full flag and a busy flag. A revision register and a feature register describe the build.

Top module: `spi_fifo_master`

## Requirements
- R1: Register byte offsets are control-0 0x00, control-1 0x04, control-2 0x08, status 0x0C, data 0x18, revision 0x60 and feature 0x64. The feature register holds frame-width-minus-one (31) in bits 7:0, receive depth minus one in bits 15:8 and transmit depth minus one in bits 23:16. Control registers read back their stored fields, and any other offset reads zero.
- R2: After reset all control fields are zero, both FIFOs are empty, status reads 0x2, no clock edge is produced and every chip-select line is low.
- R3: A frame is started only while control-2 bit 0 (enable) and bit 8 (transmit enable) are both set, control-0 bits 3:2 equal 3 (master) and control-0 bits 14:12 equal 1 (SPI format). Otherwise transmit words stay queued.
- R4: The serial clock idles low and has a period of 2×(div+1) input clocks, where div is control-1 bits 15:0. The output bit changes after a falling edge and the input is sampled on a rising edge.
- R5: A frame is control-1 bits 20:16 plus one bits long and taken from the low bits of the word. It is sent MSB first, or LSB first when control-0 bit 6 is set. A received bit lands at the position of the bit sent in the same slot.
- R6: When control-0 bit 7 is set, the receive path takes the outgoing bit stream instead of the input pin.
- R7: When control-2 bit 1 (data output enable) is clear, the output data pin stays low while frames are still shifted.
- R8: A completed frame is written to the receive FIFO only while control-2 bit 7 (receive enable) is set.
- R9: Writing 1 to control-2 bit 2 empties the receive FIFO, and writing 1 to bit 3 empties the transmit FIFO, both within one cycle. These two bits always read back as zero.
- R10: Data writes to a full transmit FIFO are dropped. Frames that complete while the receive FIFO is full are discarded. A data read from an empty receive FIFO returns zero.
- R11: Status bit 0 is receive FIFO full, bit 1 transmit FIFO not full and bit 2 busy. Bits 8:4 hold the receive count and bits 16:12 the transmit count. Busy is high from the loading of the first frame until the last bit is shifted with no further queued frame.
- R12: The chip-select line chosen by control-2 bits 11:10 is driven to control-2 bit 9. All other lines sit at the inactive level, which is high when control-0 bit 5 is set and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| cs_out | output | 4 | Chip-select lines |

## Verification
The transfer path is driven with several word patterns: asymmetric bytes both MSB-first and LSB-first, a 16-bit frame, an all-ones word with the output disabled, and a loopback run. Between them these separate bit-order faults, length faults, output-enable faults and faults in the receive source selection. A bench slave feeds a known input stream, so received words show whether sampling lands on the right edge and in the right slot. Queue boundaries are tried by overfilling the transmit side and letting the receive side overflow. The first and last stored words and the empty read then show that exactly the right words were dropped. A run with the mode fields wrong and a run with transmit enable off confirm that nothing starts.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int FRAME_MAX = 32;
    localparam int LEN_W     = 5;
    localparam int DIV_W     = 16;
    localparam int NUM_CS    = 4;

    localparam logic [7:0] OFS_CTRL0 = 8'h00;
    localparam logic [7:0] OFS_CTRL1 = 8'h04;
    localparam logic [7:0] OFS_CTRL2 = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h0C;
    localparam logic [7:0] OFS_DATA  = 8'h18;
    localparam logic [7:0] OFS_REV   = 8'h60;
    localparam logic [7:0] OFS_FEAT  = 8'h64;

    typedef enum logic {ENG_IDLE = 1'b0, ENG_SHIFT = 1'b1} eng_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign count   = q.cnt;
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = empty ? '0 : mem_q[q.rd];

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (do_push) d.wr = (q.wr == AW'(DEPTH - 1)) ? '0 : q.wr + AW'(1);
            if (do_pop)  d.rd = (q.rd == AW'(DEPTH - 1)) ? '0 : q.rd + AW'(1);
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + CW'(1);
                2'b01:   d.cnt = q.cnt - CW'(1);
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q.wr] <= wdata;
    end

    // R10
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));

    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 tx_empty,
    input  logic [FRAME_MAX-1:0] tx_word,
    input  logic [LEN_W-1:0]     frame_len,
    input  logic [DIV_W-1:0]     div,
    input  logic                 lsb_first,
    input  logic                 out_en,
    input  logic                 loopback,
    input  logic                 miso,
    output logic                 tx_pop,
    output logic                 rx_push,
    output logic [FRAME_MAX-1:0] rx_word,
    output logic                 sclk,
    output logic                 mosi,
    output logic                 busy
);
    typedef struct packed {
        eng_state_e           st;
        logic [DIV_W-1:0]     hc;
        logic [LEN_W-1:0]     bitc;
        logic [LEN_W-1:0]     len;
        logic                 lsb;
        logic                 sclk;
        logic [FRAME_MAX-1:0] txw;
        logic [FRAME_MAX-1:0] rxw;
    } eng_t;

    eng_t q, d;
    logic [LEN_W-1:0] idx;
    logic mosi_raw, sample, load_ok, do_load;

    assign idx      = q.lsb ? (q.len - q.bitc) : q.bitc;
    assign mosi_raw = (q.st == ENG_SHIFT) && q.txw[idx];
    assign sample   = loopback ? mosi_raw : miso;
    assign load_ok  = run && !tx_empty;

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        do_load = 1'b0;
        if (q.st == ENG_IDLE) begin
            do_load = load_ok;
        end else if (q.hc == div) begin
            d.hc   = '0;
            d.sclk = ~q.sclk;
            if (!q.sclk) begin
                d.rxw[idx] = sample;
            end else if (q.bitc == '0) begin
                rx_push = 1'b1;
                if (load_ok) do_load = 1'b1;
                else         d.st = ENG_IDLE;
            end else begin
                d.bitc = q.bitc - LEN_W'(1);
            end
        end else begin
            d.hc = q.hc + DIV_W'(1);
        end
        if (do_load) begin
            tx_pop = 1'b1;
            d.st   = ENG_SHIFT;
            d.hc   = '0;
            d.sclk = 1'b0;
            d.txw  = tx_word;
            d.rxw  = '0;
            d.bitc = frame_len;
            d.len  = frame_len;
            d.lsb  = lsb_first;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_word = q.rxw;
    assign sclk    = q.sclk;
    assign mosi    = out_en && mosi_raw;
    assign busy    = (q.st == ENG_SHIFT);

    // R4
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(tx_empty) || !$past(run)));

    // R4
    frame_end_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !sclk);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int          TX_DEPTH = 16,
    parameter int          RX_DEPTH = 16,
    parameter logic [31:0] REV_ID   = 32'h0002_0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic [3:0]  cs_out
);
    localparam int TCW = $clog2(TX_DEPTH + 1);
    localparam int RCW = $clog2(RX_DEPTH + 1);

    typedef struct packed {
        logic [1:0]       mode;
        logic [2:0]       fmt;
        logic             cspol;
        logic             lsb;
        logic             lb;
        logic [DIV_W-1:0] div;
        logic [LEN_W-1:0] flen;
        logic             en;
        logic             txdoe;
        logic             rxen;
        logic             txen;
        logic             cslvl;
        logic [1:0]       cssel;
    } regs_t;

    regs_t q, d;
    logic wr_c0, wr_c1, wr_c2, wr_dat, rd_dat;
    logic tx_clr, rx_clr, run;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [TCW-1:0] tx_cnt;
    logic [RCW-1:0] rx_cnt;
    logic [FRAME_MAX-1:0] tx_head, rx_head, eng_rx_word;
    logic eng_pop, eng_push, eng_busy;
    logic unused_wbits;

    assign wr_c0  = bus_sel && bus_wr && (bus_addr == OFS_CTRL0);
    assign wr_c1  = bus_sel && bus_wr && (bus_addr == OFS_CTRL1);
    assign wr_c2  = bus_sel && bus_wr && (bus_addr == OFS_CTRL2);
    assign wr_dat = bus_sel && bus_wr && (bus_addr == OFS_DATA);
    assign rd_dat = bus_sel && !bus_wr && (bus_addr == OFS_DATA);
    assign tx_clr = wr_c2 && bus_wdata[3];
    assign rx_clr = wr_c2 && bus_wdata[2];
    assign unused_wbits = ^bus_wdata[31:21];

    always_comb begin
        d = q;
        if (wr_c0) begin
            d.mode  = bus_wdata[3:2];
            d.cspol = bus_wdata[5];
            d.lsb   = bus_wdata[6];
            d.lb    = bus_wdata[7];
            d.fmt   = bus_wdata[14:12];
        end
        if (wr_c1) begin
            d.div  = bus_wdata[15:0];
            d.flen = bus_wdata[20:16];
        end
        if (wr_c2) begin
            d.en    = bus_wdata[0];
            d.txdoe = bus_wdata[1];
            d.rxen  = bus_wdata[7];
            d.txen  = bus_wdata[8];
            d.cslvl = bus_wdata[9];
            d.cssel = bus_wdata[11:10];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run = q.en && q.txen && (q.mode == 2'd3) && (q.fmt == 3'd1);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL0: bus_rdata = {17'd0, q.fmt, 4'd0, q.lb, q.lsb, q.cspol, 1'b0, q.mode, 2'd0};
            OFS_CTRL1: bus_rdata = {11'd0, q.flen, q.div};
            OFS_CTRL2: bus_rdata = {20'd0, q.cssel, q.cslvl, q.txen, q.rxen, 5'd0, q.txdoe, q.en};
            OFS_STAT:  bus_rdata = {15'd0, 5'(tx_cnt), 3'd0, 5'(rx_cnt), 1'b0, eng_busy, !tx_full, rx_full};
            OFS_DATA:  bus_rdata = rx_head;
            OFS_REV:   bus_rdata = REV_ID;
            OFS_FEAT:  bus_rdata = {8'd0, 8'(TX_DEPTH - 1), 8'(RX_DEPTH - 1), 8'(FRAME_MAX - 1)};
            default:   bus_rdata = '0;
        endcase
    end

    spim_fifo #(.W(FRAME_MAX), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(wr_dat), .wdata(bus_wdata),
        .pop(eng_pop), .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(FRAME_MAX), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(eng_push && q.rxen), .wdata(eng_rx_word),
        .pop(rd_dat), .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spim_engine u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .tx_empty(tx_empty), .tx_word(tx_head),
        .frame_len(q.flen), .div(q.div), .lsb_first(q.lsb), .out_en(q.txdoe),
        .loopback(q.lb), .miso(spi_miso), .tx_pop(eng_pop), .rx_push(eng_push),
        .rx_word(eng_rx_word), .sclk(spi_sclk), .mosi(spi_mosi), .busy(eng_busy)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_out[i] = (q.cssel == 2'(i)) ? q.cslvl : q.cspol;
    end

    // R9
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c2 && bus_wdata[3]) |=> (tx_cnt == '0));

    // R12
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_out ^ {NUM_CS{q.cspol}}) <= 1);

    // R3
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !eng_busy) |=> !eng_busy);

    // R10
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dat && rx_empty) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_spi_fifo_master.sv
`timescale 1ns/1ps
module sim_spi_fifo_master;
    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [7:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic sclk, mosi, miso;
    logic [3:0] cs_out;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [63:0] ms = 0, cap = 0;
    int ptr = 0, rises = 0, cyc = 0;
    bit mosi_hi = 0;

    localparam logic [31:0] EN = 32'h1, DOE = 32'h2, RXC = 32'h4, TXC = 32'h8;
    localparam logic [31:0] RXEN = 32'h80, TXEN = 32'h100, LVL = 32'h200;
    localparam logic [31:0] RUN = EN | DOE | RXEN | TXEN;

    always #10 clk = ~clk;

    spi_fifo_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .cs_out(cs_out)
    );

    assign miso = ms[6'(63 - ptr)];
    always @(negedge sclk) ptr = ptr + 1;
    always @(posedge sclk) begin
        cap = {cap[62:0], mosi};
        rises = rises + 1;
    end
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mosi) mosi_hi = 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic slave_reset(input logic [63:0] stream);
        ms = stream; ptr = 0; cap = 0; rises = 0; mosi_hi = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        repeat (4) @(posedge clk);
        for (int i = 0; i < 5000; i++) begin
            rd(8'h0C, s);
            if (!s[2] && s[16:12] == 0) break;
        end
    endtask

    function automatic logic [31:0] cr0(input bit lsb, input bit lb);
        return 32'h1000 | 32'h000C | 32'h0020 | (32'(lsb) << 6) | (32'(lb) << 7);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk(v == 0, "R2 ctrl0 reset", v, 0);
        rd(8'h08, v); chk(v == 0, "R2 ctrl2 reset", v, 0);
        rd(8'h0C, v); chk(v == 32'h2, "R2 status reset", v, 32'h2);
        chk(cs_out == 4'b0000 && sclk == 0, "R2 pins reset", {28'd0, cs_out}, 0);
        rd(8'h60, v); chk(v == 32'h0002_0100, "R1 revision", v, 32'h0002_0100);
        rd(8'h64, v); chk(v == 32'h000F_0F1F, "R1 feature", v, 32'h000F_0F1F);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(8'h04, 32'h0007_0003); rd(8'h04, v); chk(v == 32'h0007_0003, "R1 ctrl1 readback", v, 32'h0007_0003);
        wr(8'h00, cr0(1, 1)); rd(8'h00, v); chk(v == 32'h10EC, "R1 ctrl0 readback", v, 32'h10EC);
        rd(8'h10, v); chk(v == 0, "R1 unmapped offset", v, 0);
        wr(8'h08, 32'hE8F); rd(8'h08, v); chk(v == 32'hE83, "R9 clear bits read zero", v, 32'hE83);
        wr(8'h08, 0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        slave_reset(0);
        wr(8'h04, 32'h0007_0000);
        wr(8'h00, cr0(0, 0));
        wr(8'h08, EN | DOE | RXEN);
        wr(8'h18, 32'h55);
        repeat (40) @(posedge clk);
        rd(8'h0C, v);
        chk(v[16:12] == 1 && !v[2] && rises == 0, "R3 no start without transmit enable", v, 32'h1002);
        wr(8'h00, 32'h000C | 32'h0020);
        wr(8'h08, RUN);
        repeat (40) @(posedge clk);
        rd(8'h0C, v);
        chk(v[16:12] == 1 && rises == 0, "R3 no start without SPI format", v, 32'h1002);
        wr(8'h08, TXC | RXC);
        rd(8'h0C, v); chk(v[16:12] == 0, "R9 tx clear", v, 32'h2);
    endtask

    task automatic t_basic();
        logic [31:0] v, v2;
        slave_reset(64'hC35A_0000_0000_0000);
        wr(8'h00, cr0(0, 0));
        wr(8'h04, 32'h0007_0003);
        wr(8'h08, RUN | (32'd2 << 10));
        chk(cs_out == 4'b1011, "R12 selected line low", {28'd0, cs_out}, 32'hB);
        wr(8'h18, 32'h1A5);
        wr(8'h18, 32'h3C);
        rd(8'h0C, v); chk(v[2] == 1, "R11 busy during transfer", v, 32'h4);
        wait_idle();
        chk(cap[15:0] == 16'hA53C, "R5 MSB-first bytes on output", {16'd0, cap[15:0]}, 32'hA53C);
        rd(8'h0C, v); chk(v[8:4] == 2 && !v[2], "R11 rx count after two frames", v, 32'h22);
        rd(8'h18, v); rd(8'h18, v2);
        chk(v == 32'hC3 && v2 == 32'h5A, "R4 rising-edge sampling of input", v2, 32'h5A);
        wr(8'h08, RUN | LVL | (32'd2 << 10));
        chk(cs_out == 4'b1111, "R12 level bit drives selected line", {28'd0, cs_out}, 32'hF);
    endtask

    task automatic t_div();
        int c0, c1;
        slave_reset(0);
        wr(8'h04, 32'h0007_0003);
        wr(8'h18, 32'h81);
        @(posedge sclk); c0 = cyc;
        @(posedge sclk); c1 = cyc;
        chk((c1 - c0) == 8, "R4 clock period 2*(div+1)", 32'(c1 - c0), 8);
        wait_idle();
        chk(cap[7:0] == 8'h81, "R4 frame with div 3", {24'd0, cap[7:0]}, 32'h81);
        wr(8'h08, RUN | RXC);
    endtask

    task automatic t_lsb();
        logic [31:0] v;
        slave_reset(0);
        wr(8'h00, cr0(1, 0));
        wr(8'h04, 32'h0007_0001);
        wr(8'h18, 32'h01);
        wait_idle();
        chk(cap[7:0] == 8'h80, "R5 LSB-first order", {24'd0, cap[7:0]}, 32'h80);
        slave_reset(0);
        wr(8'h00, cr0(0, 0));
        wr(8'h04, 32'h000F_0000);
        wr(8'h18, 32'hFFFF_1234);
        wait_idle();
        chk(cap[15:0] == 16'h1234 && rises == 16, "R5 16-bit frame", {16'd0, cap[15:0]}, 32'h1234);
        wr(8'h08, RUN | RXC);
        rd(8'h18, v);
    endtask

    task automatic t_loop();
        logic [31:0] v;
        slave_reset(0);
        wr(8'h00, cr0(0, 1));
        wr(8'h04, 32'h0007_0000);
        wr(8'h18, 32'h96);
        wait_idle();
        rd(8'h18, v); chk(v == 32'h96, "R6 loopback returns sent word", v, 32'h96);
        wr(8'h00, cr0(0, 0));
    endtask

    task automatic t_txdoe();
        slave_reset(0);
        wr(8'h08, EN | RXEN | TXEN);
        wr(8'h18, 32'hFF);
        wait_idle();
        chk(!mosi_hi && rises == 8, "R7 output held low when disabled", {31'd0, mosi_hi}, 0);
        wr(8'h08, RUN | RXC);
    endtask

    task automatic t_rxen();
        logic [31:0] v;
        slave_reset(64'hFFFF_0000_0000_0000);
        wr(8'h08, EN | DOE | TXEN);
        wr(8'h18, 32'h11);
        wait_idle();
        rd(8'h0C, v); chk(v[8:4] == 0 && rises == 8, "R8 no capture without receive enable", v, 32'h2);
        wr(8'h08, RUN);
        wr(8'h18, 32'h11); wr(8'h18, 32'h22);
        wait_idle();
        wr(8'h08, RUN | RXC);
        rd(8'h0C, v); chk(v[8:4] == 0, "R9 rx clear", v, 32'h2);
    endtask

    task automatic t_full();
        logic [31:0] v;
        bit ok;
        slave_reset(0);
        wr(8'h00, cr0(0, 1));
        wr(8'h08, EN | DOE | RXEN);
        for (int i = 0; i < 17; i++) wr(8'h18, 32'h10 + 32'(i));
        rd(8'h0C, v); chk(v[16:12] == 16 && !v[1], "R10 tx full drops write", v, 32'h10000);
        wr(8'h08, RUN);
        wait_idle();
        rd(8'h0C, v); chk(v[8:4] == 16 && v[0], "R11 rx full flag", v, 32'h103);
        wr(8'h18, 32'hEE); wr(8'h18, 32'hEF);
        wait_idle();
        ok = 1;
        for (int i = 0; i < 16; i++) begin
            rd(8'h18, v);
            if (v != 32'h10 + 32'(i)) ok = 0;
        end
        chk(ok, "R10 overflow frames discarded", v, 32'h1F);
        rd(8'h18, v); chk(v == 0, "R10 empty read returns zero", v, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_regs();
        t_gate();
        t_basic();
        t_div();
        t_lsb();
        t_loop();
        t_txdoe();
        t_rxen();
        t_full();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule